// File: doc/BRIEF.md
# Ternary Prefix Match Table

This block is a small ternary match array for next-hop lookup. It keeps a set of rule slots, each with a stored value, a compare mask and a valid flag, in flip-flops. A destination key is compared against every slot in the same cycle. A slot matches when the key agrees with the stored value on every bit where the mask is 1. Mask bits that are 0 are don't-care. When several slots match, the lowest-numbered slot wins. The winning slot number also addresses a parallel next-hop store, which returns the forwarding result for that rule.

Prefix rules are rules whose mask is a run of 1s from the most significant bit followed by 0s. If software loads them with the longest prefixes at the lowest slot numbers, the winning slot is the longest matching prefix. Software writes or clears one slot at a time through a single write port. A lookup strobe captures a key, and the hit flag, winning slot and next hop appear on the outputs at the next clock edge. The outputs then hold until the next strobe.

Top module: `tpm_lookup`

## Requirements
- R1: While reset is asserted and right after it is released, res_hit, res_index and res_hop are 0, every slot is invalid, and any key misses.
- R2: A valid slot matches a key exactly when, for every bit position where the slot's mask is 1, the key bit equals the stored value bit; mask-0 positions are ignored (e.g. value 0x2C with mask 0x1D matches keys 0x2C, 0x2E, 0x0C, 0x0E and rejects 0x2D).
- R3: When several valid slots match, the reported slot is the lowest-numbered one.
- R4: With prefix rules stored in order of decreasing prefix length from slot 0 upward, a lookup reports the longest prefix covering the key (e.g. table 011*, 000*, 11*, 01*, 00*, 0*, * in slots 0 to 6 and key 011001xx selects slot 0).
- R5: On a hit, res_hop equals the next-hop value last written with the winning slot.
- R6: When no valid slot matches, res_hit is 0 and both res_index and res_hop are 0.
- R7: A write with wr_en=1 and wr_ins=0 clears the slot at wr_slot, and that slot never matches afterwards until it is inserted again.
- R8: A write with wr_en=1 and wr_ins=1 replaces the slot's value, mask and next hop and marks the slot valid, taking effect for lookups strobed from the next cycle onward.
- R9: Results appear on the first rising edge after the cycle in which lk_strobe is 1, and they hold unchanged in every cycle that has no strobe.
- R10: A lookup strobed in the same cycle as a write sees the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Table write strobe |
| wr_ins | input | 1 | 1 = insert/replace the slot, 0 = delete the slot |
| wr_slot | input | IDX_W | Slot number being written |
| wr_value | input | KEY_W | Rule value |
| wr_mask | input | KEY_W | Rule mask, 1 = bit compared |
| wr_hop | input | HOP_W | Next-hop value stored for the slot |
| lk_strobe | input | 1 | Lookup request |
| lk_key | input | KEY_W | Destination key |
| res_hit | output | 1 | A valid slot matched |
| res_index | output | IDX_W | Winning slot, 0 on a miss |
| res_hop | output | HOP_W | Next hop of the winning slot, 0 on a miss |

## Verification
The checker watches every cycle. It checks that a miss leaves the index and next hop at zero and that outputs stay put without a strobe. It checks that the reported slot was matching in the strobe cycle and that no lower slot was matching. It also checks that inserts and deletes set or clear the slot's valid flag one edge later. Whether the match rule honours the mask, whether prefix ordering yields the longest prefix, which next-hop value comes back, and the old-contents behaviour of a colliding write and lookup can only be shown by the bench. It sweeps every 8-bit key against a model table after each load.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  typedef enum logic {
    OP_DELETE = 1'b0,
    OP_INSERT = 1'b1
  } wr_op_e;
endpackage

// File: rtl/tpm_rst_sync.sv
module tpm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/tpm_entry_bank.sv
module tpm_entry_bank #(
  parameter int KEY_W   = 8,
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_ins,
  input  logic [IDX_W-1:0]   wr_slot,
  input  logic [KEY_W-1:0]   wr_value,
  input  logic [KEY_W-1:0]   wr_mask,
  input  logic [KEY_W-1:0]   key,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] match_vec
);
  import tpm_pkg::*;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic             sel;
    logic             load;
    logic             vld_q;
    logic             vld_d;
    logic [KEY_W-1:0] val_q;
    logic [KEY_W-1:0] msk_q;
    logic [KEY_W-1:0] diff;

    assign sel  = wr_en && (wr_slot == IDX_W'(g));
    assign load = sel && (wr_op_e'(wr_ins) == OP_INSERT);

    always_comb begin
      vld_d = vld_q;
      if (sel) vld_d = (wr_op_e'(wr_ins) == OP_INSERT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    // Pattern storage has no reset; the valid flag gates it.
    always_ff @(posedge clk) begin
      if (load) begin
        val_q <= wr_value & wr_mask;
        msk_q <= wr_mask;
      end
    end

    assign diff         = (key ^ val_q) & msk_q;
    assign match_vec[g] = vld_q && (diff == '0);
    assign valid_vec[g] = vld_q;
  end
endmodule

// File: rtl/tpm_prio_enc.sv
module tpm_prio_enc #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/tpm_hop_ram.sv
module tpm_hop_ram #(
  parameter int ENTRIES = 16,
  parameter int HOP_W   = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [HOP_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [HOP_W-1:0] rdata
);
  logic [HOP_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < ENTRIES)) mem[waddr] <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (int'(raddr) < ENTRIES) rdata = mem[raddr];
  end
endmodule

// File: rtl/tpm_lookup.sv
module tpm_lookup #(
  parameter int KEY_W   = 8,
  parameter int ENTRIES = 16,
  parameter int HOP_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_ins,
  input  logic [IDX_W-1:0] wr_slot,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic [HOP_W-1:0] wr_hop,
  input  logic             lk_strobe,
  input  logic [KEY_W-1:0] lk_key,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_index,
  output logic [HOP_W-1:0] res_hop
);
  import tpm_pkg::*;

  logic               rst_sync_n;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] match_vec;
  logic               enc_any;
  logic [IDX_W-1:0]   enc_idx;
  logic [HOP_W-1:0]   rd_hop;
  logic               hop_we;

  logic               hit_q,  hit_d;
  logic [IDX_W-1:0]   idx_q,  idx_d;
  logic [HOP_W-1:0]   hop_q,  hop_d;

  tpm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tpm_entry_bank #(
    .KEY_W   (KEY_W),
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_ins    (wr_ins),
    .wr_slot   (wr_slot),
    .wr_value  (wr_value),
    .wr_mask   (wr_mask),
    .key       (lk_key),
    .valid_vec (valid_vec),
    .match_vec (match_vec)
  );

  tpm_prio_enc #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_enc (
    .req (match_vec),
    .any (enc_any),
    .idx (enc_idx)
  );

  assign hop_we = wr_en && (wr_op_e'(wr_ins) == OP_INSERT);

  tpm_hop_ram #(
    .ENTRIES (ENTRIES),
    .HOP_W   (HOP_W),
    .IDX_W   (IDX_W)
  ) u_hops (
    .clk   (clk),
    .we    (hop_we),
    .waddr (wr_slot),
    .wdata (wr_hop),
    .raddr (enc_idx),
    .rdata (rd_hop)
  );

  // Next-state: a miss forces index and hop to zero.
  always_comb begin
    hit_d = enc_any;
    idx_d = enc_any ? enc_idx : '0;
    hop_d = enc_any ? rd_hop  : '0;
  end

  // Result register, enabled by the lookup strobe.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hit_q <= 1'b0;
      idx_q <= '0;
      hop_q <= '0;
    end else if (lk_strobe) begin
      hit_q <= hit_d;
      idx_q <= idx_d;
      hop_q <= hop_d;
    end
  end

  assign res_hit   = hit_q;
  assign res_index = idx_q;
  assign res_hop   = hop_q;
endmodule

// File: rtl/tpm_lookup_chk.sv
module tpm_lookup_chk #(
  parameter int ENTRIES = 16,
  parameter int HOP_W   = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               wr_en,
  input logic               wr_ins,
  input logic [IDX_W-1:0]   wr_slot,
  input logic               lk_strobe,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] match_vec,
  input logic               res_hit,
  input logic [IDX_W-1:0]   res_index,
  input logic [HOP_W-1:0]   res_hop
);
  logic [ENTRIES-1:0] below_mask;
  logic [ENTRIES-1:0] win_bit;

  always_comb begin
    win_bit    = ENTRIES'(1) << res_index;
    below_mask = win_bit - ENTRIES'(1);
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!res_hit && res_index == '0 && res_hop == '0 && valid_vec == '0));

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !res_hit |-> (res_index == '0 && res_hop == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lk_strobe |=> $stable({res_hit, res_index, res_hop}));

  // R3
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(lk_strobe) && res_hit) |->
      ((($past(match_vec) & win_bit) != '0) && (($past(match_vec) & below_mask) == '0)));

  // R7
  delete_clears_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_ins && int'(wr_slot) < ENTRIES) |=> !valid_vec[$past(wr_slot)]);

  // R8
  insert_sets_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_ins && int'(wr_slot) < ENTRIES) |=> valid_vec[$past(wr_slot)]);
endmodule

bind tpm_lookup tpm_lookup_chk #(
  .ENTRIES (ENTRIES),
  .HOP_W   (HOP_W),
  .IDX_W   (IDX_W)
) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_ins     (wr_ins),
  .wr_slot    (wr_slot),
  .lk_strobe  (lk_strobe),
  .valid_vec  (valid_vec),
  .match_vec  (match_vec),
  .res_hit    (res_hit),
  .res_index  (res_index),
  .res_hop    (res_hop)
);

// File: tb/tpm_lookup_tb_top.sv
`timescale 1ns/1ps
module tpm_lookup_tb_top;
  localparam int KW = 8;
  localparam int NE = 16;
  localparam int HW = 8;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en = 1'b0;
  logic          wr_ins = 1'b0;
  logic [IW-1:0] wr_slot = '0;
  logic [KW-1:0] wr_value = '0;
  logic [KW-1:0] wr_mask = '0;
  logic [HW-1:0] wr_hop = '0;
  logic          lk_strobe = 1'b0;
  logic [KW-1:0] lk_key = '0;
  logic          res_hit;
  logic [IW-1:0] res_index;
  logic [HW-1:0] res_hop;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [KW-1:0] m_val [NE];
  logic [KW-1:0] m_msk [NE];
  logic [HW-1:0] m_hop [NE];
  logic          m_vld [NE];

  logic          e_hit;
  logic [IW-1:0] e_idx;
  logic [HW-1:0] e_hop;

  always #2 clk = ~clk;

  tpm_lookup #(.KEY_W(KW), .ENTRIES(NE), .HOP_W(HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ins(wr_ins),
    .wr_slot(wr_slot), .wr_value(wr_value), .wr_mask(wr_mask),
    .wr_hop(wr_hop), .lk_strobe(lk_strobe), .lk_key(lk_key),
    .res_hit(res_hit), .res_index(res_index), .res_hop(res_hop)
  );

  task automatic model_expect(input logic [KW-1:0] key);
    e_hit = 1'b0; e_idx = '0; e_hop = '0;
    for (int i = NE - 1; i >= 0; i--) begin
      if (m_vld[i] && (((key ^ m_val[i]) & m_msk[i]) == '0)) begin
        e_hit = 1'b1; e_idx = IW'(i); e_hop = m_hop[i];
      end
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (res_hit !== e_hit || res_index !== e_idx || res_hop !== e_hop) begin
      errors++;
      $display("FAIL %s: got hit=%0b idx=%0d hop=%0h expected hit=%0b idx=%0d hop=%0h",
               tag, res_hit, res_index, res_hop, e_hit, e_idx, e_hop);
    end
  endtask

  task automatic model_write(input int slot, input bit ins, input logic [KW-1:0] v,
                             input logic [KW-1:0] m, input logic [HW-1:0] h);
    m_vld[slot] = ins;
    if (ins) begin m_val[slot] = v; m_msk[slot] = m; m_hop[slot] = h; end
  endtask

  task automatic do_write(input int slot, input bit ins, input logic [KW-1:0] v,
                          input logic [KW-1:0] m, input logic [HW-1:0] h);
    wr_en = 1'b1; wr_ins = ins; wr_slot = IW'(slot);
    wr_value = v; wr_mask = m; wr_hop = h;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(slot, ins, v, m, h);
  endtask

  task automatic do_lookup(input logic [KW-1:0] key, input string tag);
    model_expect(key);
    lk_strobe = 1'b1; lk_key = key;
    @(negedge clk);
    lk_strobe = 1'b0;
    compare(tag);
  endtask

  task automatic sweep(input string tag);
    for (int k = 0; k < 256; k++) do_lookup(KW'(k), tag);
  endtask

  function automatic logic [KW-1:0] pmask(input int len);
    return ~(KW'(8'hFF) >> len);
  endfunction

  initial begin : main
    for (int i = 0; i < NE; i++) begin
      m_vld[i] = 1'b0; m_val[i] = '0; m_msk[i] = '0; m_hop[i] = '0;
    end
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while in reset
    e_hit = 1'b0; e_idx = '0; e_hop = '0;
    compare("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 after release");
    sweep("R1 empty table misses");

    // R2: ternary compare with non-prefix mask
    do_write(0, 1'b1, 8'h2C, 8'h1D, 8'h5A);
    do_lookup(8'h2C, "R2 exact"); do_lookup(8'h2E, "R2 dc bit1");
    do_lookup(8'h0C, "R2 dc bit5"); do_lookup(8'h0E, "R2 dc both");
    do_lookup(8'h2D, "R2 cared bit differs");
    sweep("R2 sweep");

    // R4 / R5: prefix table, longest first
    do_write(0, 1'b1, 8'h60, pmask(3), 8'hA0);
    do_write(1, 1'b1, 8'h00, pmask(3), 8'hA1);
    do_write(2, 1'b1, 8'hC0, pmask(2), 8'hA2);
    do_write(3, 1'b1, 8'h40, pmask(2), 8'hA3);
    do_write(4, 1'b1, 8'h00, pmask(2), 8'hA4);
    do_write(5, 1'b1, 8'h00, pmask(1), 8'hA5);
    do_write(6, 1'b1, 8'h00, pmask(0), 8'hA6);
    do_lookup(8'b0110_0100, "R4 key 011001 picks 011*");
    do_lookup(8'b0101_0000, "R4 key picks 01*");
    do_lookup(8'b1000_0000, "R4 key picks *");
    sweep("R4 R5 prefix sweep");

    // R3: overlapping arbitrary rules in all slots
    for (int i = 0; i < NE; i++)
      do_write(i, 1'b1, KW'(i * 37 + 5), KW'(8'hFF << (i % 8)) & KW'(8'hF7 >> (i % 3)),
               HW'(i * 11 + 1));
    sweep("R3 overlap sweep");

    // R7: deletes
    do_write(0, 1'b0, '0, '0, '0);
    do_write(5, 1'b0, '0, '0, '0);
    sweep("R7 after deletes");
    for (int i = 0; i < NE; i++) do_write(i, 1'b0, '0, '0, '0);
    sweep("R6 all deleted");

    // R8: insert and overwrite
    do_write(9, 1'b1, 8'h80, 8'h80, 8'h11);
    do_lookup(8'h9F, "R8 inserted");
    do_write(9, 1'b1, 8'h01, 8'h01, 8'h22);
    do_lookup(8'h9F, "R8 overwritten");
    do_lookup(8'h9E, "R8 old pattern gone");

    // R9: hold without strobe
    do_lookup(8'h01, "R9 capture");
    lk_key = 8'h00;
    repeat (4) @(negedge clk);
    compare("R9 held");

    // R10: colliding write and lookup
    model_expect(8'h03);
    wr_en = 1'b1; wr_ins = 1'b0; wr_slot = 4'd9; lk_strobe = 1'b1; lk_key = 8'h03;
    @(negedge clk);
    wr_en = 1'b0; lk_strobe = 1'b0;
    compare("R10 delete same cycle sees old");
    model_write(9, 1'b0, '0, '0, '0);
    do_lookup(8'h03, "R10 delete visible next");
    model_expect(8'h44);
    wr_en = 1'b1; wr_ins = 1'b1; wr_slot = 4'd2; wr_value = 8'h44; wr_mask = 8'hFF;
    wr_hop = 8'h77; lk_strobe = 1'b1; lk_key = 8'h44;
    @(negedge clk);
    wr_en = 1'b0; lk_strobe = 1'b0;
    compare("R10 insert same cycle sees old");
    model_write(2, 1'b1, 8'h44, 8'hFF, 8'h77);
    do_lookup(8'h44, "R10 insert visible next");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule